// File: doc/BRIEF.md
# Comma-Aligning Receive Deserializer

This block is the receive half of one serial channel. It takes a recovered serial bit stream, one bit per bit-clock cycle, and cuts it into 10-bit characters. While alignment is enabled it looks for the positive-disparity K28.5 comma at every bit offset. When it finds one, it moves the character boundary so that the comma becomes the next character presented. Each character leaves the block on a 5-bit bus as a leading half and then a trailing half. The halves go out together with two complementary output clocks at the character rate.

The leading half of every character appears on the rising edge of the lead clock. The trailing half appears on the rising edge of the trail clock. A destination can therefore latch on the rising edges of both clocks, or on both edges of one clock. A comma flag marks each character period that carries an aligned comma. A loopback input replaces the line data with 5-bit halves supplied by the transmit side. In that mode the character boundary keeps running from its last position. Clock recovery is outside the block; the bit clock is given.

Top module: `comma_align_deser`

## Requirements
- R1: During and right after a synchronous reset, `rx_half` is 0, `rclk_lead` is 0, `rclk_trail` is 1 and `comma_seen` is 0.
- R2: The comma is the 10-bit pattern 0011111010, with the leftmost bit received first. If `align_en` is high and not in loopback, the comma is found at any of the ten bit offsets. Its character is then presented two cycles after its last bit is sampled, and that leading half is 5'b00111.
- R3: A character made of the bits sampled at edges E-10 to E-1 is presented from edge E+1. Bit 4 of `rx_half` carries the earliest bit. Edge E+1 shows the leading half (first five bits). Edge E+6 shows the trailing half (last five bits). `rx_half` changes only on an edge where `rclk_lead` toggles.
- R4: `rclk_trail` is always the inverse of `rclk_lead`. `rclk_lead` rises with each leading half and falls with each trailing half. Without realignment each level lasts 5 cycles. Across a realignment a high level never exceeds 5 cycles and a low level never exceeds 6.
- R5: `comma_seen` changes only on a rising edge of `rclk_lead`. It is 1 for the whole character period of an aligned comma and 0 for other characters.
- R6: While `align_en` is low, commas cause no realignment: characters keep the existing 10-cycle boundary, and `comma_seen` stays 0.
- R7: While `loop_en` is high, `lb_half` is presented in place of line data. It is sampled on the edge where `rclk_lead` rises and again on the edge where it falls to give the trailing half. Commas on the line neither move the boundary nor raise `comma_seen`.
- R8: When a realignment lands while `rclk_lead` is high, `rclk_lead` first drops for a cycle. This makes the comma's leading half coincide with a true rising edge.
- R9: After reset, the free-running boundary makes the first ten bits sampled after reset release the first line character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_bit | input | 1 | Recovered serial bit |
| align_en | input | 1 | Enables comma search and boundary realignment |
| loop_en | input | 1 | Selects transmit-side halves instead of line data |
| lb_half | input | 5 | Transmit-side half for loopback |
| rx_half | output | 5 | Leading or trailing half of the current character |
| rclk_lead | output | 1 | Character-rate clock, rises with the leading half |
| rclk_trail | output | 1 | Complement of `rclk_lead`, rises with the trailing half |
| comma_seen | output | 1 | High during the character period of an aligned comma |

## Verification
The bench steps a comma through all ten bit offsets relative to the running boundary. This includes the offset that already matches the boundary. It also covers the offset one bit past it, where a realignment collides with a presentation still pending. A design that recounts the offset wrongly would show the comma's halves split across two characters. A design without the forced drop would show the comma's leading half on a clock that was already high. The bench then sends a comma with alignment disabled and another in loopback. A design that ignored either control would jump its boundary and raise the flag. Leaving loopback checks that line data returns on the kept boundary.

// File: rtl/cad_pkg.sv
package cad_pkg;
  localparam int unsigned SYM_BITS = 10;
  localparam logic [SYM_BITS-1:0] K28_5_POS = 10'b0011111010;
endpackage

// File: rtl/cad_bit_window.sv
module cad_bit_window #(
  parameter int unsigned SYM_W = cad_pkg::SYM_BITS,
  parameter logic [SYM_W-1:0] PATTERN = cad_pkg::K28_5_POS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  output logic [SYM_W-1:0] window,
  output logic             hit
);
  // oldest bit sits in the MSB
  always_ff @(posedge clk) begin
    if (rst) window <= '0;
    else     window <= {window[SYM_W-2:0], bit_in};
  end

  assign hit = (window == PATTERN);
endmodule

// File: rtl/cad_framer.sv
module cad_framer #(
  parameter int unsigned SYM_W = cad_pkg::SYM_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic align_en,
  input  logic loop_en,
  output logic boundary,
  output logic comma_ok
);
  localparam int unsigned PW = $clog2(SYM_W);
  localparam logic [PW-1:0] LAST = PW'(SYM_W - 1);

  logic [PW-1:0] pos;

  assign comma_ok = hit & align_en & ~loop_en;
  assign boundary = (pos == LAST) | comma_ok;

  always_ff @(posedge clk) begin
    if (rst)           pos <= LAST;
    else if (boundary) pos <= '0;
    else               pos <= pos + 1'b1;
  end
endmodule

// File: rtl/cad_half_out.sv
module cad_half_out #(
  parameter int unsigned SYM_W = cad_pkg::SYM_BITS,
  localparam int unsigned HALF_W = SYM_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary,
  input  logic              comma_ok,
  input  logic [SYM_W-1:0]  window,
  input  logic              loop_en,
  input  logic [HALF_W-1:0] lb_half,
  output logic [HALF_W-1:0] rx_half,
  output logic              clk_lead,
  output logic              clk_trail,
  output logic              comma_seen
);
  localparam int unsigned CW = $clog2(SYM_W);
  localparam logic [CW-1:0] TRAIL_AT = CW'(HALF_W - 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(SYM_W - 1);

  logic              pend;
  logic [SYM_W-1:0]  pend_sym;
  logic              pend_comma;
  logic [HALF_W-1:0] trail_q;
  logic [CW-1:0]     cnt;
  logic              trail_due;
  logic [HALF_W-1:0] trail_src;
  logic [HALF_W-1:0] lead_src;

  assign trail_due = clk_lead & (cnt == TRAIL_AT);
  assign trail_src = loop_en ? lb_half : trail_q;
  assign lead_src  = loop_en ? lb_half : pend_sym[SYM_W-1 -: HALF_W];

  // staging: capture at the boundary, present one cycle later
  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      pend_sym   <= '0;
      pend_comma <= 1'b0;
    end else begin
      pend <= boundary;
      if (boundary) begin
        pend_sym   <= window;
        pend_comma <= comma_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_half    <= '0;
      trail_q    <= '0;
      clk_lead   <= 1'b0;
      clk_trail  <= 1'b1;
      comma_seen <= 1'b0;
      cnt        <= CNT_MAX;
    end else if (boundary) begin
      // guarantee a low level before the next leading half
      if (trail_due) rx_half <= trail_src;
      clk_lead  <= 1'b0;
      clk_trail <= 1'b1;
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end else if (pend) begin
      rx_half    <= lead_src;
      trail_q    <= pend_sym[HALF_W-1:0];
      clk_lead   <= 1'b1;
      clk_trail  <= 1'b0;
      comma_seen <= pend_comma;
      cnt        <= '0;
    end else begin
      if (trail_due) begin
        rx_half   <= trail_src;
        clk_lead  <= 1'b0;
        clk_trail <= 1'b1;
      end
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/comma_align_deser.sv
module comma_align_deser #(
  parameter int unsigned SYM_W = cad_pkg::SYM_BITS,
  parameter logic [SYM_W-1:0] COMMA = cad_pkg::K28_5_POS,
  localparam int unsigned HALF_W = SYM_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_bit,
  input  logic              align_en,
  input  logic              loop_en,
  input  logic [HALF_W-1:0] lb_half,
  output logic [HALF_W-1:0] rx_half,
  output logic              rclk_lead,
  output logic              rclk_trail,
  output logic              comma_seen
);
  logic [SYM_W-1:0] window;
  logic             hit;
  logic             boundary;
  logic             comma_ok;

  cad_bit_window #(.SYM_W(SYM_W), .PATTERN(COMMA)) u_window (
    .clk(clk), .rst(rst), .bit_in(ser_bit), .window(window), .hit(hit)
  );

  cad_framer #(.SYM_W(SYM_W)) u_framer (
    .clk(clk), .rst(rst), .hit(hit), .align_en(align_en), .loop_en(loop_en),
    .boundary(boundary), .comma_ok(comma_ok)
  );

  cad_half_out #(.SYM_W(SYM_W)) u_out (
    .clk(clk), .rst(rst), .boundary(boundary), .comma_ok(comma_ok),
    .window(window), .loop_en(loop_en), .lb_half(lb_half),
    .rx_half(rx_half), .clk_lead(rclk_lead), .clk_trail(rclk_trail),
    .comma_seen(comma_seen)
  );
endmodule

// File: rtl/comma_align_deser_chk.sv
module comma_align_deser_chk #(
  parameter int unsigned SYM_W = cad_pkg::SYM_BITS,
  localparam int unsigned HALF_W = SYM_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              align_en,
  input logic              loop_en,
  input logic [HALF_W-1:0] rx_half,
  input logic              rclk_lead,
  input logic              rclk_trail,
  input logic              comma_seen
);
  localparam int unsigned RW = $clog2(SYM_W) + 1;
  localparam logic [RW-1:0] HIGH_MAX = RW'(HALF_W);
  localparam logic [RW-1:0] LOW_MAX  = RW'(HALF_W + 1);
  localparam logic [RW-1:0] SAT      = '1;

  logic [RW-1:0] low_run;
  logic [RW-1:0] high_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= '0;
      high_run <= '0;
    end else begin
      low_run  <= rclk_lead ? '0 : ((low_run == SAT) ? SAT : low_run + 1'b1);
      high_run <= !rclk_lead ? '0 : ((high_run == SAT) ? SAT : high_run + 1'b1);
    end
  end

  AST_CLK_PAIR: assert property (@(posedge clk) disable iff (rst)
    rclk_trail == !rclk_lead); // R4
  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    low_run <= LOW_MAX); // R4
  AST_HIGH_BOUND: assert property (@(posedge clk) disable iff (rst)
    high_run <= HIGH_MAX); // R4
  AST_HALF_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_half) |-> !$stable(rclk_lead)); // R3
  AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    !$rose(rclk_lead) |-> $stable(comma_seen)); // R5
  AST_NO_FLAG_UNALIGNED: assert property (@(posedge clk) disable iff (rst)
    ($rose(rclk_lead) && !$past(align_en)) |-> !comma_seen); // R6
  AST_NO_FLAG_LOOP: assert property (@(posedge clk) disable iff (rst)
    ($rose(rclk_lead) && $past(loop_en)) |-> !comma_seen); // R7
endmodule

bind comma_align_deser comma_align_deser_chk #(.SYM_W(SYM_W)) u_chk (
  .clk(clk), .rst(rst), .align_en(align_en), .loop_en(loop_en),
  .rx_half(rx_half), .rclk_lead(rclk_lead), .rclk_trail(rclk_trail),
  .comma_seen(comma_seen)
);

// File: tb/test_comma_align_deser.sv
`timescale 1ns/1ps
module test_comma_align_deser;
  localparam logic [9:0] COMMA = 10'b0011111010;
  localparam logic [9:0] DA    = 10'b1010101010;
  localparam logic [9:0] DB    = 10'b0101010101;
  localparam int HMAX = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_bit = 1'b0;
  logic align_en = 1'b1;
  logic loop_en = 1'b0;
  logic [4:0] lb_half = '0;
  logic [4:0] rx_half;
  logic rclk_lead, rclk_trail, comma_seen;

  comma_align_deser i_comma_align_deser (
    .clk(clk), .rst(rst), .ser_bit(ser_bit), .align_en(align_en),
    .loop_en(loop_en), .lb_half(lb_half), .rx_half(rx_half),
    .rclk_lead(rclk_lead), .rclk_trail(rclk_trail), .comma_seen(comma_seen)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic       bits [0:HMAX-1];
  logic [4:0] lbs  [0:HMAX-1];
  logic [4:0] hh   [0:HMAX-1];
  logic       ha   [0:HMAX-1];
  logic       hb   [0:HMAX-1];
  logic       hf   [0:HMAX-1];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input logic b, input logic [4:0] lv);
    ser_bit = b;
    lb_half = lv;
    @(posedge clk);
    cyc++;
    bits[cyc] = b;
    lbs[cyc]  = lv;
    #1;
    hh[cyc] = rx_half;
    ha[cyc] = rclk_lead;
    hb[cyc] = rclk_trail;
    hf[cyc] = comma_seen;
  endtask

  task automatic send_sym(input logic [9:0] s);
    for (int i = 9; i >= 0; i--) send(s[i], 5'd0);
  endtask

  function automatic logic [4:0] half_at(input int first);
    logic [4:0] v;
    for (int i = 0; i < 5; i++) v[4-i] = bits[first+i];
    return v;
  endfunction

  // character boundary edge E: presented from E+1, trailing at E+6
  task automatic check_frame(input int e, input logic [4:0] lead,
                             input logic [4:0] trail, input logic flag,
                             input string req);
    chk(ha[e] == 1'b0, "R8", "lead clock low before rise", ha[e], 0);
    chk(ha[e+1] == 1'b1 && hb[e+1] == 1'b0, "R4", "clocks at leading half",
        {ha[e+1], hb[e+1]}, 2);
    chk(hh[e+1] == lead, req, "leading half", hh[e+1], lead);
    chk(hf[e+1] == flag, "R5", "flag at leading half", hf[e+1], flag);
    chk(hh[e+5] == lead && ha[e+5] == 1'b1, "R3", "leading half held",
        hh[e+5], lead);
    chk(ha[e+6] == 1'b0 && hb[e+6] == 1'b1, "R4", "clocks at trailing half",
        {ha[e+6], hb[e+6]}, 1);
    chk(hh[e+6] == trail, req, "trailing half", hh[e+6], trail);
    chk(hh[e+9] == trail && hf[e+9] == flag, "R5", "trailing half and flag held",
        {hf[e+9], hh[e+9]}, {flag, trail});
  endtask

  task automatic check_line(input int e, input logic flag, input string req);
    check_frame(e, half_at(e-10), half_at(e-5), flag, req);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ec;
    repeat (3) @(posedge clk);
    #1;
    chk(rx_half == 5'd0, "R1", "rx_half in reset", rx_half, 0);
    chk(rclk_lead == 1'b0 && rclk_trail == 1'b1, "R1", "clocks in reset",
        {rclk_lead, rclk_trail}, 1);
    chk(comma_seen == 1'b0, "R1", "flag in reset", comma_seen, 0);
    rst = 1'b0;

    // sweep the comma across every offset of the running boundary
    ec = 0;
    for (int off = 0; off < 10; off++) begin
      for (int p = 0; p < 10 + off; p++) send(1'b1, 5'd0);
      send_sym(COMMA);
      ec = cyc;
      send_sym(DA);
      send_sym(DB);
      if (off == 0) check_line(11, 1'b0, "R9");
      check_line(ec + 1, 1'b1, "R2");
      chk(hh[ec+2] == 5'b00111, "R2", "comma leading half", hh[ec+2], 5'b00111);
      check_line(ec + 11, 1'b0, "R3");
    end

    // alignment disabled: a comma at offset 3 is ignored
    align_en = 1'b0;
    for (int p = 0; p < 3; p++) send(1'b1, 5'd0);
    send_sym(COMMA);
    for (int p = 0; p < 27; p++) send(1'b1, 5'd0);
    for (int k = 0; k < 4; k++) check_line(ec + 21 + 10*k, 1'b0, "R6");

    // loopback: transmit halves replace line data, comma on line ignored
    align_en = 1'b1;
    loop_en  = 1'b1;
    for (int p = 0; p < 40; p++) begin
      logic [9:0] s;
      logic [4:0] lv;
      s  = {4'b1111, COMMA[9:4]};
      lv = 5'((cyc + 1) * 7 + 3);
      if (p < 4)       send(1'b1, lv);
      else if (p < 14) send(COMMA[13-p], lv);
      else             send(1'b1, lv);
      if (s == 10'd0) send(1'b0, 5'd0);
    end
    for (int k = 0; k < 4; k++) begin
      int e;
      e = ec + 61 + 10*k;
      check_frame(e, lbs[e+1], lbs[e+6], 1'b0, "R7");
    end

    // leave loopback: line data returns on the kept boundary
    loop_en = 1'b0;
    for (int p = 0; p < 20; p++) send(1'b1, 5'd0);
    check_line(ec + 101, 1'b0, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule